// File: doc/BRIEF.md
# Disk-Backed Page Cache Tag Controller

This block decides, for every host memory request, whether the addressed page already sits in DRAM or must first be moved to or from a disk. It keeps a small direct-mapped tag store. Each entry holds a stored tag, a valid flag and a dirty flag. A request whose page is present goes straight to the DRAM back end. A request that misses raises a disk command first. If the entry it displaces is valid and dirty, that command is an eviction write of the old page. For a read it is then a fill read of the requested page. A write miss claims the page without reading anything from disk. Once the entry has been updated, the same request is looked up again, now hits, and is passed to DRAM.

Host addresses are line addresses. A page holds 64 lines, so the low 6 bits select the line and the bits above them form the page number. The low `IDX_W` page bits pick the tag entry, and the remaining upper page bits are the stored tag. Only one request is in flight at a time; the host port is held off until the DRAM handshake for that request completes. A maintenance port writes any entry directly. This lets a test force hits or misses over chosen address ranges. The DRAM and disk back ends are plain valid/acknowledge handshakes.

Top module: `page_cache_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1, `disk_valid_o` and `dram_valid_o` are 0, and every tag entry is invalid, so the first access to any page misses.
- R2: A maintenance write (`mnt_we_i`) sets the tag, valid and dirty bits of entry `mnt_idx_i` from the next cycle on. When it targets the entry that the controller updates in the same cycle, the maintenance values are kept and the controller update is lost. A lookup in that same cycle still sees the old entry.
- R3: A request to a valid entry with a matching tag issues no disk command and presents `dram_valid_o` with `dram_addr_o` equal to the request address and `dram_write_o` equal to its type. A write hit sets the entry's dirty bit; a read hit leaves it unchanged.
- R4: A read that misses onto a clean or invalid entry issues one disk read (`disk_write_o`=0) of the requested page (`disk_page_o` = address bits [ADDR_W-1:6]). The entry then becomes valid and clean with the new tag.
- R5: A miss onto a valid, dirty entry first issues a disk write (`disk_write_o`=1) whose page is {stored tag, index}. It is followed by the disk read for a read miss, or by no further disk command for a write miss.
- R6: A write miss never issues a disk read. The entry is claimed valid with the new tag, and the write then hits, leaving the entry dirty.
- R7: After the acknowledge of a fill read, `dram_valid_o` rises exactly two cycles later: one cycle for the repeated lookup, and then the DRAM command.
- R8: `req_ready_o` falls in the cycle after a request is accepted and stays low until the cycle after the DRAM acknowledge. Requests offered meanwhile are not taken.
- R9: While `disk_valid_o` or `dram_valid_o` is high and not acknowledged, the command fields (`disk_write_o`, `disk_page_o` or `dram_write_o`, `dram_addr_o`) stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request offered |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Host line address |
| req_ready_o | output | 1 | Controller idle, request taken on valid |
| mnt_we_i | input | 1 | Maintenance write strobe |
| mnt_idx_i | input | IDX_W | Entry to overwrite |
| mnt_tag_i | input | TAG_W | Tag value to store |
| mnt_valid_i | input | 1 | Valid value to store |
| mnt_dirty_i | input | 1 | Dirty value to store |
| disk_valid_o | output | 1 | Disk command pending |
| disk_write_o | output | 1 | 1 = eviction write, 0 = fill read |
| disk_page_o | output | PAGE_W | Page number of the disk command |
| disk_ack_i | input | 1 | Disk command completed |
| dram_valid_o | output | 1 | DRAM command pending |
| dram_write_o | output | 1 | DRAM command type |
| dram_addr_o | output | ADDR_W | DRAM line address |
| dram_ack_i | input | 1 | DRAM command completed |

## Verification
The maintenance port and the controller's own entry update can land on the same entry in the same cycle. The bench provokes this by raising a maintenance write that invalidates the entry in the very cycle it acknowledges a fill read. The maintenance write must win: the repeated lookup misses again, and a second fill read of the same page must follow before any DRAM command. The reference model in the bench applies the controller update first and the maintenance write over it. It is compared with the ports on every clock, and a directed check counts the disk reads of that request.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_EVICT = 3'd2,
    ST_FILL  = 3'd3,
    ST_DRAM  = 3'd4
  } pcc_state_e;
endpackage

// File: rtl/pcc_tag_store.sv
module pcc_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mnt_we_i,
  input  logic [IDX_W-1:0] mnt_idx_i,
  input  logic [TAG_W-1:0] mnt_tag_i,
  input  logic             mnt_valid_i,
  input  logic             mnt_dirty_i,
  input  logic             upd_we_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic             upd_dirty_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             rd_valid_o,
  output logic             rd_dirty_o
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_a   [ENTRIES];
  logic             valid_a [ENTRIES];
  logic             dirty_a [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [TAG_W-1:0] tag_q;
    logic             valid_q, dirty_q;
    logic             mnt_hit, upd_hit;

    assign mnt_hit = mnt_we_i && (mnt_idx_i == IDX_W'(e));
    assign upd_hit = upd_we_i && (upd_idx_i == IDX_W'(e));

    // maintenance port has priority over controller updates
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q   <= '0;
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
      end else if (mnt_hit) begin
        tag_q   <= mnt_tag_i;
        valid_q <= mnt_valid_i;
        dirty_q <= mnt_dirty_i;
      end else if (upd_hit) begin
        tag_q   <= upd_tag_i;
        valid_q <= 1'b1;
        dirty_q <= upd_dirty_i;
      end
    end

    assign tag_a[e]   = tag_q;
    assign valid_a[e] = valid_q;
    assign dirty_a[e] = dirty_q;
  end

  assign rd_tag_o   = tag_a[rd_idx_i];
  assign rd_valid_o = valid_a[rd_idx_i];
  assign rd_dirty_o = dirty_a[rd_idx_i];
endmodule

// File: rtl/pcc_tag_compare.sv
module pcc_tag_compare #(
  parameter int TAG_W = 6
) (
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic             ent_valid_i,
  input  logic             ent_dirty_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             hit_o,
  output logic             victim_dirty_o
);
  assign hit_o          = ent_valid_i && (ent_tag_i == req_tag_i);
  assign victim_dirty_o = ent_valid_i && ent_dirty_i;
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 6,
  parameter int IDX_W  = 4,
  parameter int PAGE_W = ADDR_W - LINE_W,
  parameter int TAG_W  = PAGE_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  input  logic              hit_i,
  input  logic              victim_dirty_i,
  input  logic [TAG_W-1:0]  victim_tag_i,
  output logic              upd_we_o,
  output logic              upd_dirty_o,
  output logic              disk_valid_o,
  output logic              disk_write_o,
  output logic [PAGE_W-1:0] disk_page_o,
  input  logic              disk_ack_i,
  output logic              dram_valid_o,
  output logic              dram_write_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  input  logic              dram_ack_i
);
  pcc_state_e        state_q, state_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] victim_q;
  logic [PAGE_W-1:0] page;

  assign page     = addr_q[ADDR_W-1:LINE_W];
  assign lk_idx_o = page[IDX_W-1:0];
  assign lk_tag_o = page[PAGE_W-1:IDX_W];

  always_comb begin
    state_d     = state_q;
    upd_we_o    = 1'b0;
    upd_dirty_o = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_LOOK;
      ST_LOOK: begin
        if (hit_i) begin
          upd_we_o    = wr_q;          // write hit marks page dirty
          upd_dirty_o = 1'b1;
          state_d     = ST_DRAM;
        end else if (victim_dirty_i) begin
          state_d = ST_EVICT;
        end else if (wr_q) begin
          upd_we_o = 1'b1;             // claim page, no disk read
          state_d  = ST_LOOK;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_EVICT: begin
        if (disk_ack_i) begin
          upd_we_o = wr_q;
          state_d  = wr_q ? ST_LOOK : ST_FILL;
        end
      end
      ST_FILL: begin
        if (disk_ack_i) begin
          upd_we_o = 1'b1;
          state_d  = ST_LOOK;
        end
      end
      ST_DRAM:  if (dram_ack_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      victim_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        wr_q   <= req_write_i;
        addr_q <= req_addr_i;
      end
      if (state_q == ST_LOOK && !hit_i && victim_dirty_i)
        victim_q <= {victim_tag_i, lk_idx_o};
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign disk_valid_o = (state_q == ST_EVICT) || (state_q == ST_FILL);
  assign disk_write_o = (state_q == ST_EVICT);
  assign disk_page_o  = (state_q == ST_EVICT) ? victim_q : page;
  assign dram_valid_o = (state_q == ST_DRAM);
  assign dram_write_o = wr_q;
  assign dram_addr_o  = addr_q;
endmodule

// File: rtl/page_cache_ctrl.sv
module page_cache_ctrl #(
  parameter int ADDR_W         = 16,
  parameter int LINES_PER_PAGE = 64,
  parameter int IDX_W          = 4,
  localparam int LINE_W        = $clog2(LINES_PER_PAGE),
  localparam int PAGE_W        = ADDR_W - LINE_W,
  localparam int TAG_W         = PAGE_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  input  logic              mnt_we_i,
  input  logic [IDX_W-1:0]  mnt_idx_i,
  input  logic [TAG_W-1:0]  mnt_tag_i,
  input  logic              mnt_valid_i,
  input  logic              mnt_dirty_i,
  output logic              disk_valid_o,
  output logic              disk_write_o,
  output logic [PAGE_W-1:0] disk_page_o,
  input  logic              disk_ack_i,
  output logic              dram_valid_o,
  output logic              dram_write_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  input  logic              dram_ack_i
);
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag, ent_tag;
  logic             ent_valid, ent_dirty;
  logic             hit, victim_dirty;
  logic             upd_we, upd_dirty;

  pcc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .mnt_we_i, .mnt_idx_i, .mnt_tag_i, .mnt_valid_i, .mnt_dirty_i,
    .upd_we_i    (upd_we),
    .upd_idx_i   (lk_idx),
    .upd_tag_i   (lk_tag),
    .upd_dirty_i (upd_dirty),
    .rd_idx_i    (lk_idx),
    .rd_tag_o    (ent_tag),
    .rd_valid_o  (ent_valid),
    .rd_dirty_o  (ent_dirty)
  );

  pcc_tag_compare #(.TAG_W(TAG_W)) u_cmp (
    .ent_tag_i      (ent_tag),
    .ent_valid_i    (ent_valid),
    .ent_dirty_i    (ent_dirty),
    .req_tag_i      (lk_tag),
    .hit_o          (hit),
    .victim_dirty_o (victim_dirty)
  );

  pcc_ctrl #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .IDX_W(IDX_W),
    .PAGE_W(PAGE_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_ready_o,
    .lk_idx_o       (lk_idx),
    .lk_tag_o       (lk_tag),
    .hit_i          (hit),
    .victim_dirty_i (victim_dirty),
    .victim_tag_i   (ent_tag),
    .upd_we_o       (upd_we),
    .upd_dirty_o    (upd_dirty),
    .disk_valid_o, .disk_write_o, .disk_page_o, .disk_ack_i,
    .dram_valid_o, .dram_write_o, .dram_addr_o, .dram_ack_i
  );
endmodule

// File: rtl/page_cache_ctrl_chk.sv
module page_cache_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mnt_we_i,
  input logic              disk_valid_o,
  input logic              disk_write_o,
  input logic [PAGE_W-1:0] disk_page_o,
  input logic              disk_ack_i,
  input logic              dram_valid_o,
  input logic              dram_write_o,
  input logic [ADDR_W-1:0] dram_addr_o,
  input logic              dram_ack_i
);
  a_r9_disk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disk_valid_o && !disk_ack_i |=> disk_valid_o && $stable(disk_page_o) && $stable(disk_write_o));

  a_r9_dram_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_valid_o && !dram_ack_i |=> dram_valid_o && $stable(dram_addr_o) && $stable(dram_write_o));

  a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_valid_o && dram_ack_i |=> req_ready_o);

  a_r7_relook_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disk_valid_o && disk_ack_i && !disk_write_o && !mnt_we_i |-> ##2 dram_valid_o);

  a_r5_evict_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disk_valid_o && disk_ack_i && disk_write_o && !dram_write_o |=> disk_valid_o && !disk_write_o);
endmodule

bind page_cache_ctrl page_cache_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .mnt_we_i,
  .disk_valid_o, .disk_write_o, .disk_page_o, .disk_ack_i,
  .dram_valid_o, .dram_write_o, .dram_addr_o, .dram_ack_i
);

// File: tb/page_cache_ctrl_test.sv
`timescale 1ns/1ps
module page_cache_ctrl_test;
  localparam int AW = 16, IW = 4, TW = 6, PW = 10;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic          req_valid_i = 0, req_write_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_ready_o;
  logic          mnt_we_i = 0, mnt_valid_i = 0, mnt_dirty_i = 0;
  logic [IW-1:0] mnt_idx_i = '0;
  logic [TW-1:0] mnt_tag_i = '0;
  logic          disk_valid_o, disk_write_o, disk_ack_i = 0;
  logic [PW-1:0] disk_page_o;
  logic          dram_valid_o, dram_write_o, dram_ack_i = 0;
  logic [AW-1:0] dram_addr_o;

  page_cache_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i, .req_write_i, .req_addr_i, .req_ready_o,
    .mnt_we_i, .mnt_idx_i, .mnt_tag_i, .mnt_valid_i, .mnt_dirty_i,
    .disk_valid_o, .disk_write_o, .disk_page_o, .disk_ack_i,
    .dram_valid_o, .dram_write_o, .dram_addr_o, .dram_ack_i
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] la(input int t, input int i, input int l);
    return {TW'(t), IW'(i), 6'(l)};
  endfunction

  // ---------------- reference model ----------------
  logic [TW-1:0] m_tag [16];
  bit            m_v [16], m_d [16];
  int            ph;               // 0 idle 1 look 2 evict 3 fill 4 dram
  bit            r_w;
  logic [AW-1:0] r_a;
  logic [PW-1:0] vic;

  always @(posedge clk or negedge rst_n) begin
    int ix; logic [TW-1:0] tg; bit uw, ud;
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin m_tag[k] = '0; m_v[k] = 0; m_d[k] = 0; end
      ph = 0; r_w = 0; r_a = '0; vic = '0;
    end else begin
      ix = int'(r_a[9:6]); tg = r_a[15:10]; uw = 0; ud = 0;
      case (ph)
        0: if (req_valid_i) begin r_w = req_write_i; r_a = req_addr_i; ph = 1; end
        1: begin
          if (m_v[ix] && m_tag[ix] == tg) begin
            if (r_w) begin uw = 1; ud = 1; end
            ph = 4;
          end else if (m_v[ix] && m_d[ix]) begin
            vic = {m_tag[ix], IW'(ix)}; ph = 2;
          end else if (r_w) begin uw = 1; ph = 1; end
          else ph = 3;
        end
        2: if (disk_ack_i) begin if (r_w) begin uw = 1; ph = 1; end else ph = 3; end
        3: if (disk_ack_i) begin uw = 1; ph = 1; end
        4: if (dram_ack_i) ph = 0;
        default: ph = 0;
      endcase
      if (uw) begin m_tag[ix] = tg; m_v[ix] = 1; m_d[ix] = ud; end
      if (mnt_we_i) begin
        m_tag[mnt_idx_i] = mnt_tag_i; m_v[mnt_idx_i] = mnt_valid_i; m_d[mnt_idx_i] = mnt_dirty_i;
      end
    end
  end

  // ---------------- responders and monitors ----------------
  int  cyc = 0, lat_disk = 1, lat_dram = 1, dcnt = 0, rcnt = 0;
  int  n_rd = 0, n_wr = 0, first_op = -1, fill_cyc = -100, dram_rise = -100;
  logic [PW-1:0] last_rd_pg, last_wr_pg;
  logic [AW-1:0] last_dram_a;
  bit  last_dram_w, prev_dv = 0;
  bit  coll_arm = 0, coll_drv = 0;
  logic [IW-1:0] coll_idx;

  task automatic clr_mon();
    n_rd = 0; n_wr = 0; first_op = -1;
  endtask

  always @(negedge clk) begin
    logic [29:0] act, exp;
    cyc++;
    if (rst_n) begin
      act = {req_ready_o, disk_valid_o, disk_valid_o ? disk_write_o : 1'b0,
             disk_valid_o ? disk_page_o : PW'(0), dram_valid_o,
             dram_valid_o ? dram_write_o : 1'b0, dram_valid_o ? dram_addr_o : AW'(0)};
      exp = {ph == 0, ph == 2 || ph == 3, ph == 2,
             ph == 2 ? vic : (ph == 3 ? r_a[15:6] : PW'(0)), ph == 4,
             ph == 4 ? r_w : 1'b0, ph == 4 ? r_a : AW'(0)};
      chk(act == exp, "R9 cycle model", act, exp);
    end
    if (dram_valid_o && !prev_dv) dram_rise = cyc;
    prev_dv = dram_valid_o;
    if (disk_ack_i) begin
      disk_ack_i = 0; dcnt = 0;
      if (coll_drv) begin mnt_we_i = 0; coll_drv = 0; end
    end else if (disk_valid_o) begin
      if (dcnt >= lat_disk) begin
        disk_ack_i = 1;
        if (first_op < 0) first_op = int'(disk_write_o);
        if (disk_write_o) begin n_wr++; last_wr_pg = disk_page_o; end
        else begin n_rd++; last_rd_pg = disk_page_o; fill_cyc = cyc; end
        if (coll_arm) begin
          mnt_idx_i = coll_idx; mnt_tag_i = '0; mnt_valid_i = 0; mnt_dirty_i = 0;
          mnt_we_i = 1; coll_arm = 0; coll_drv = 1;
        end
      end else dcnt++;
    end
    if (dram_ack_i) begin dram_ack_i = 0; rcnt = 0; end
    else if (dram_valid_o) begin
      if (rcnt >= lat_dram) begin
        dram_ack_i = 1; last_dram_a = dram_addr_o; last_dram_w = dram_write_o;
      end else rcnt++;
    end
  end

  task automatic host(input bit w, input logic [AW-1:0] a);
    @(negedge clk); req_write_i = w; req_addr_i = a; req_valid_i = 1;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk); req_valid_i = 0;
    while (!req_ready_o) @(negedge clk);
  endtask

  task automatic mnt(input int i, input int t, input bit v, input bit d);
    @(negedge clk); mnt_idx_i = IW'(i); mnt_tag_i = TW'(t); mnt_valid_i = v; mnt_dirty_i = d; mnt_we_i = 1;
    @(negedge clk); mnt_we_i = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 50000) begin
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected<=50000", cyc);
    summary();
  end

  // ---------------- directed scenarios ----------------
  initial begin
    logic [PW-1:0] p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready_o == 1, "R1 ready after reset", req_ready_o, 1);
    chk(disk_valid_o == 0, "R1 disk idle after reset", disk_valid_o, 0);
    chk(dram_valid_o == 0, "R1 dram idle after reset", dram_valid_o, 0);

    // R1/R4/R7: first access misses, fill read, relookup hit
    clr_mon(); lat_disk = 2; lat_dram = 1;
    host(0, la(0, 0, 5));
    chk(n_rd == 1 && n_wr == 0, "R1 invalid entry misses", n_rd, 1);
    chk(last_rd_pg == PW'(0), "R4 fill page", last_rd_pg, 0);
    chk(dram_rise - fill_cyc == 2, "R7 relookup delay", dram_rise - fill_cyc, 2);
    chk(last_dram_a == la(0, 0, 5) && !last_dram_w, "R3 dram after fill", last_dram_a, la(0, 0, 5));

    // R3 read hit
    clr_mon();
    host(0, la(0, 0, 9));
    chk(n_rd + n_wr == 0, "R3 read hit no disk", n_rd + n_wr, 0);
    chk(last_dram_a == la(0, 0, 9), "R3 read hit addr", last_dram_a, la(0, 0, 9));

    // R2 preload, R3 write hit sets dirty, R5 eviction then fill
    mnt(1, 7, 1, 0);
    clr_mon(); lat_dram = 3;
    host(1, la(7, 1, 3));
    chk(n_rd + n_wr == 0, "R2 preloaded hit", n_rd + n_wr, 0);
    chk(last_dram_w == 1 && last_dram_a == la(7, 1, 3), "R3 write hit dram", last_dram_a, la(7, 1, 3));
    clr_mon(); lat_disk = 0;
    host(0, la(8, 1, 0));
    chk(n_wr == 1 && last_wr_pg == {6'd7, 4'd1}, "R3 write hit left dirty", last_wr_pg, {6'd7, 4'd1});
    chk(first_op == 1, "R5 eviction first", first_op, 1);
    chk(n_rd == 1 && last_rd_pg == {6'd8, 4'd1}, "R5 fill after eviction", last_rd_pg, {6'd8, 4'd1});

    // R3 read hit leaves clean
    mnt(2, 3, 1, 0);
    clr_mon(); host(0, la(3, 2, 0));
    chk(n_rd + n_wr == 0, "R3 clean read hit", n_rd + n_wr, 0);
    clr_mon(); host(0, la(4, 2, 0));
    chk(n_wr == 0 && n_rd == 1, "R3 read hit kept clean", n_wr, 0);

    // R6 write miss without disk read
    clr_mon(); lat_disk = 3;
    host(1, la(5, 3, 1));
    chk(n_rd + n_wr == 0, "R6 write miss no disk", n_rd + n_wr, 0);
    chk(last_dram_w == 1 && last_dram_a == la(5, 3, 1), "R6 write miss dram", last_dram_a, la(5, 3, 1));
    clr_mon(); host(0, la(6, 3, 0));
    chk(n_wr == 1 && last_wr_pg == {6'd5, 4'd3}, "R6 allocated page dirty", last_wr_pg, {6'd5, 4'd3});

    // R5 dirty victim on write miss: eviction only
    mnt(4, 2, 1, 1);
    clr_mon(); host(1, la(9, 4, 0));
    chk(n_wr == 1 && last_wr_pg == {6'd2, 4'd4}, "R5 write miss eviction", last_wr_pg, {6'd2, 4'd4});
    chk(n_rd == 0, "R5 write miss no fill", n_rd, 0);

    // R2 maintenance invalidate forces miss
    mnt(0, 0, 0, 0);
    clr_mon(); host(0, la(0, 0, 1));
    chk(n_rd == 1, "R2 invalidated entry misses", n_rd, 1);

    // R2 collision: maintenance wins over allocation in the same cycle
    clr_mon(); coll_idx = 4'd5; coll_arm = 1; lat_disk = 1;
    host(0, la(1, 5, 0));
    chk(n_rd == 2, "R2 maintenance beats allocation", n_rd, 2);
    chk(last_dram_a == la(1, 5, 0), "R2 collision completes", last_dram_a, la(1, 5, 0));

    // R8/R9 back-pressure and hold during a slow disk command
    clr_mon(); lat_disk = 6;
    fork
      host(0, la(10, 6, 0));
      begin
        @(negedge clk); @(negedge clk);
        while (!disk_valid_o) @(negedge clk);
        @(negedge clk);
        p0 = disk_page_o;
        chk(req_ready_o == 0, "R8 busy during miss", req_ready_o, 0);
        @(negedge clk); @(negedge clk);
        chk(disk_page_o == p0 && disk_valid_o, "R9 disk page held", disk_page_o, p0);
      end
    join
    chk(req_ready_o == 1, "R8 ready after completion", req_ready_o, 1);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule